// File: doc/BRIEF.md
# Snapshot-Driven Reactive State Machine

This block is a small reactive controller that sits behind one-slot event buffers. Each input channel offers an event flag with a data word. An external scheduler grants a reaction by raising a go strobe. The engine then walks through a fixed cycle: idle, capture, execute, emit. In the capture phase it samples every event flag at once into a snapshot. In the execute phase it picks one transition from a parameterised table, using only that snapshot and the present state, and it reads the data words of the chosen inputs. In the emit phase it commits the new state, acknowledges the inputs it used and pulses the output events.

Each table entry holds four fields: a source state, a mask of required input events, a destination state and a set of output events. An entry matches when the present state equals its source state and every bit of its mask is set in the snapshot. When several entries match, the lowest index wins. When nothing matches, the engine consumes nothing, keeps its state and emits nothing. Inputs that were present but are not part of the chosen mask stay in their buffers for a later reaction. The first reaction after reset is the initial reaction. It needs no input event and always lands in the reset state.

Top module: `react_fsm`

## Requirements
- R1: While reset is held, and afterwards until a reaction runs, `busy`, `ev_ack` and `out_fire` are zero, `out_word` is zero and `cur_state` equals RESET_STATE (0 by default).
- R2: A reaction starts only in the idle phase, only when `sched_go` is high, and only when the initial reaction is still pending or some event flag is set that is not being acknowledged in that cycle. `busy` is then high for exactly three cycles (capture, execute, emit), and reactions never overlap.
- R3: The event flags are sampled all together in the capture cycle, which is the first cycle `busy` is high. A flag that rises later does not take part in that reaction.
- R4: Entry e matches when its source state equals `cur_state` and all of its mask bits are set in the snapshot. The lowest matching index wins. The default table, as (source, mask, destination, emit), is: e0 (0, 3'b011, 2, 3'b010), e1 (0, 3'b001, 1, 3'b001), e2 (1, 3'b100, 3, 3'b100), e3 (2, 3'b010, 0, 3'b011), e4 (3, 3'b110, 0, 3'b111). Bit i of a mask is channel i.
- R5: On a match, in the cycle right after `busy` falls, `ev_ack` pulses for one cycle on exactly the mask bits, `out_fire` pulses for one cycle with the entry's emit bits, and `cur_state` takes the destination state.
- R6: On a match, `out_word` becomes the XOR of the data words of the acknowledged channels, read during the execute cycle. Channel i occupies bits [i*DW +: DW] of `ev_word`. The new value appears in the emit cycle, before `out_fire` pulses, and it holds until the next matching reaction.
- R7: An empty transition (no entry matches) pulses neither `ev_ack` nor `out_fire`, and leaves `cur_state` and `out_word` unchanged.
- R8: Snapshot bits outside the chosen mask are never acknowledged.
- R9: The first reaction after reset needs no event. It sets `cur_state` to RESET_STATE, acknowledges nothing and emits nothing. When `sched_go` is low, no reaction starts, even with events present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_go | input | 1 | Scheduler grant to start a reaction |
| ev_flag | input | N_IN | Event-present flag from each input buffer |
| ev_word | input | N_IN*DW | Data word of each input buffer |
| ev_ack | output | N_IN | One-cycle consume strobe to each input buffer |
| out_word | output | DW | Output data word |
| out_fire | output | N_OUT | One-cycle output event strobes |
| busy | output | 1 | High from capture through emit |
| cur_state | output | SW | Present state |

## Verification
Some properties are checked by assertions on every cycle. A reaction always spans three busy cycles and needs a grant to start. Strobes come only right after busy falls and last one cycle. The state moves only at the end of a reaction. The data word is steady when output events fire. Other behaviour only the bench's scenarios can show. These are which entry wins under priority, that a late event is left out of the snapshot, that unselected inputs stay pending, and that empty transitions change nothing. The bench shows them by sweeping every event pattern from every reachable state against an arithmetic model of the table.

// File: rtl/react_fsm.sv
module react_fsm #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 3,
  parameter int DW    = 8,
  parameter int SW    = 2,
  parameter int N_ENT = 5,
  parameter logic [SW-1:0] RESET_STATE = '0,
  parameter logic [N_ENT*SW-1:0]    T_SRC  = {2'd3, 2'd2, 2'd1, 2'd0, 2'd0},
  parameter logic [N_ENT*N_IN-1:0]  T_MASK = {3'b110, 3'b010, 3'b100, 3'b001, 3'b011},
  parameter logic [N_ENT*SW-1:0]    T_DST  = {2'd0, 2'd0, 2'd3, 2'd1, 2'd2},
  parameter logic [N_ENT*N_OUT-1:0] T_EMIT = {3'b111, 3'b011, 3'b100, 3'b001, 3'b010}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_go,
  input  logic [N_IN-1:0]   ev_flag,
  input  logic [N_IN*DW-1:0] ev_word,
  output logic [N_IN-1:0]   ev_ack,
  output logic [DW-1:0]     out_word,
  output logic [N_OUT-1:0]  out_fire,
  output logic              busy,
  output logic [SW-1:0]     cur_state
);
  typedef enum logic [1:0] {PH_IDLE, PH_CAPT, PH_EXEC, PH_EMIT} phase_t;

  phase_t           ph;
  logic             init_pend, hit_r, start;
  logic [N_IN-1:0]  snap, take_r, ack_r;
  logic [N_OUT-1:0] emit_r, fire_r;
  logic [SW-1:0]    st, dst_r;
  logic [DW-1:0]    word_r;

  logic             m_hit;
  logic [N_IN-1:0]  m_mask;
  logic [SW-1:0]    m_dst;
  logic [N_OUT-1:0] m_emit;
  logic [DW-1:0]    m_word;

  assign start     = (ph == PH_IDLE) && sched_go && (init_pend || |(ev_flag & ~ack_r));
  assign busy      = (ph != PH_IDLE);
  assign ev_ack    = ack_r;
  assign out_fire  = fire_r;
  assign out_word  = word_r;
  assign cur_state = st;

  always_comb begin
    m_hit  = 1'b0;
    m_mask = '0;
    m_dst  = st;
    m_emit = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (T_SRC[e*SW +: SW] == st &&
          (snap & T_MASK[e*N_IN +: N_IN]) == T_MASK[e*N_IN +: N_IN]) begin
        m_hit  = 1'b1;
        m_mask = T_MASK[e*N_IN +: N_IN];
        m_dst  = T_DST[e*SW +: SW];
        m_emit = T_EMIT[e*N_OUT +: N_OUT];
      end
    end
    if (init_pend) begin
      m_hit  = 1'b1;
      m_mask = '0;
      m_dst  = RESET_STATE;
      m_emit = '0;
    end
  end

  always_comb begin
    m_word = '0;
    for (int i = 0; i < N_IN; i++)
      if (m_mask[i]) m_word = m_word ^ ev_word[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      init_pend <= 1'b1;
      snap      <= '0;
      hit_r     <= 1'b0;
      take_r    <= '0;
      dst_r     <= RESET_STATE;
      emit_r    <= '0;
      st        <= RESET_STATE;
      word_r    <= '0;
      fire_r    <= '0;
      ack_r     <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          fire_r <= '0;
          ack_r  <= '0;
          if (start) ph <= PH_CAPT;
        end
        PH_CAPT: begin
          snap <= ev_flag;
          ph   <= PH_EXEC;
        end
        PH_EXEC: begin
          hit_r  <= m_hit;
          take_r <= m_mask;
          dst_r  <= m_dst;
          emit_r <= m_emit;
          if (m_hit && !init_pend) word_r <= m_word;
          ph <= PH_EMIT;
        end
        PH_EMIT: begin
          if (hit_r) begin
            st     <= dst_r;
            fire_r <= emit_r;
            ack_r  <= take_r;
          end
          init_pend <= 1'b0;
          ph        <= PH_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/react_fsm_chk.sv
module react_fsm_chk #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 3,
  parameter int DW    = 8,
  parameter int SW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sched_go,
  input logic             busy,
  input logic [N_IN-1:0]  ev_ack,
  input logic [N_OUT-1:0] out_fire,
  input logic [DW-1:0]    out_word,
  input logic [SW-1:0]    cur_state
);
  // R2
  grant_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sched_go));

  // R2
  three_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 !busy);

  // R5
  fire_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_fire) |-> (!busy && $past(busy)));

  // R5
  ack_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_ack) |-> (!busy && $past(busy)));

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_ack) |=> (ev_ack == '0));

  // R5
  fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_fire) |=> (out_fire == '0));

  // R6
  word_before_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_fire) |-> $stable(out_word));

  // R5
  state_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_state) |-> ($past(busy) && !busy));
endmodule

bind react_fsm react_fsm_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sched_go(sched_go), .busy(busy),
  .ev_ack(ev_ack), .out_fire(out_fire), .out_word(out_word), .cur_state(cur_state)
);

// File: tb/test_react_fsm.sv
`timescale 1ns/1ps
module test_react_fsm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sched_go = 1'b0;
  logic [2:0]  ev_flag = '0;
  logic [23:0] ev_word = '0;
  logic [2:0]  ev_ack;
  logic [7:0]  out_word;
  logic [2:0]  out_fire;
  logic        busy;
  logic [1:0]  cur_state;

  int n_chk = 0, n_bad = 0;
  int ms = 0, mword = 0, seed = 0;
  bit init_pend = 1'b1;

  int t_src[5]  = '{0, 0, 1, 2, 3};
  int t_mask[5] = '{3, 1, 4, 2, 6};
  int t_dst[5]  = '{2, 1, 3, 0, 0};
  int t_emit[5] = '{2, 1, 4, 3, 7};

  always #2.5 clk = ~clk;

  react_fsm i_react_fsm (
    .clk(clk), .rst_n(rst_n), .sched_go(sched_go), .ev_flag(ev_flag),
    .ev_word(ev_word), .ev_ack(ev_ack), .out_word(out_word),
    .out_fire(out_fire), .busy(busy), .cur_state(cur_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic react(input logic [2:0] add, input logic [2:0] late);
    int s, hit, take, emit, dst, w;
    ev_flag = ev_flag | add;
    for (int i = 0; i < 3; i++) ev_word[i*8 +: 8] = 8'((seed * 37 + i * 91 + 5) % 256);
    seed++;
    s = int'(ev_flag);
    hit = 0; take = 0; emit = 0; dst = ms; w = mword;
    for (int e = 4; e >= 0; e--)
      if (t_src[e] == ms && (s & t_mask[e]) == t_mask[e]) begin
        hit = 1; take = t_mask[e]; emit = t_emit[e]; dst = t_dst[e];
      end
    if (init_pend) begin
      hit = 1; take = 0; emit = 0; dst = 0;
    end else if (hit) begin
      w = 0;
      for (int i = 0; i < 3; i++) if (take[i]) w = w ^ int'(ev_word[i*8 +: 8]);
    end
    sched_go = 1'b1;
    @(negedge clk);
    sched_go = 1'b0;
    if (s == 0 && !init_pend) begin
      chk("R2 no start without event", int'(busy), 0);
      return;
    end
    chk("R2 busy capture", int'(busy), 1);
    @(negedge clk);
    chk("R2 busy execute", int'(busy), 1);
    ev_flag = ev_flag | late;
    @(negedge clk);
    chk("R2 busy emit", int'(busy), 1);
    chk("R6 word before fire", int'(out_word), w);
    chk("R6 no fire yet", int'(out_fire), 0);
    @(negedge clk);
    chk("R2 busy done", int'(busy), 0);
    chk(hit ? "R5 ack mask" : "R7 empty no ack", int'(ev_ack), take);
    chk("R8 ack within snapshot", int'(ev_ack) & ~s, 0);
    chk(hit ? "R5 fire bits" : "R7 empty no fire", int'(out_fire), emit);
    chk(hit ? "R4 next state" : "R7 state kept", int'(cur_state), dst);
    chk("R6 word held", int'(out_word), w);
    ev_flag = ev_flag & ~3'(take);
    ms = dst; mword = w; init_pend = 1'b0;
    @(negedge clk);
    chk("R5 one-cycle ack", int'(ev_ack), 0);
    chk("R5 one-cycle fire", int'(out_fire), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset state", int'(cur_state), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle word", int'(out_word), 0);
    chk("R1 idle fire", int'(out_fire), 0);
    chk("R1 idle ack", int'(ev_ack), 0);
    ev_flag = 3'b001;
    repeat (4) begin
      @(negedge clk);
      chk("R9 no grant no start", int'(busy), 0);
    end
    ev_flag = '0;
    react(3'b000, 3'b000);              // R9 initial reaction
    react(3'b001, 3'b010);              // R3 late flag excluded
    chk("R3 late flag pending", int'(ev_flag), 3'b010);
    react(3'b000, 3'b000);              // R7 empty in state 1
    react(3'b100, 3'b000);              // R8 bit1 stays
    react(3'b100, 3'b000);              // state 3 via 110
    react(3'b011, 3'b000);              // R4 priority e0 over e1
    chk("R4 priority winner", int'(cur_state), 2);
    for (int rep = 0; rep < 6; rep++)
      for (int a = 0; a < 8; a++) react(3'(a), 3'b000);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule